// File: doc/BRIEF.md
# Multi-Pattern Coincidence Herald Matcher

This block decides whether a heralding attempt succeeded. It holds up to four coincidence patterns, each of which can be switched on or off on its own. At the end of every attempt, after all detector gate windows have closed, the sequencer pulses an evaluate strobe. The block then compares the vector of inputs that fired during that attempt against every enabled pattern.

If one or more enabled patterns equal the fired vector exactly, the block raises a one-cycle success pulse. Alongside it, a bitfield shows which patterns matched. The sequencer uses the pulse to stop looping. If nothing matches, the block stays silent, and the run ends only when the sequencer's own timeout expires.

Software loads all four patterns and their enable bits with one write to a single configuration register. A small state machine sequences the result. In ST_IDLE it waits for a strobe. The transition IDLE_TO_HIT fires on a strobe with at least one hit. ST_HIT drives the success pulse for one cycle. It leaves by HIT_TO_IDLE when the next cycle has no matching strobe, or stays put by HIT_TO_HIT when that cycle carries another matching strobe.

Top module: `herald_matcher`

## Requirements
- R1: Reset (rst_n low, asynchronous) drives success_o and match_o to 0 at once and clears the configuration register, so every pattern is disabled after reset.
- R2: Pattern i is held in configuration bits [4i+3:4i]. Bit j of a pattern stands for fired input j, so the MSB is input 3 and the LSB is input 0.
- R3: The enable for pattern i is configuration bit 16+i. A pattern whose enable is 0 never sets its match bit.
- R4: An enabled pattern matches only when the fired vector equals it bit for bit. An extra fired input, or a missing one, is a mismatch.
- R5: When eval_i is sampled high at a rising edge and at least one enabled pattern matches, success_o is 1 for the following cycle. It drops after that one cycle unless the next cycle also carries a matching strobe.
- R6: While success_o is 1, bit i of match_o is 1 exactly when pattern i matched at that strobe. Several bits may be set together.
- R7: Without eval_i, the fired inputs have no effect, and success_o stays 0.
- R8: When no enable bit is set, no strobe ever produces success_o.
- R9: A configuration write takes effect at the edge that samples cfg_we_i. A strobe sampled at that same edge is evaluated against the previous contents.
- R10: match_o is all zeros whenever success_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wdata_i | input | 20 | Pattern fields in bits 15:0, enables in bits 19:16 |
| fired_i | input | 4 | Inputs that fired in the current attempt, bit j = input j |
| eval_i | input | 1 | End-of-gate evaluate strobe |
| success_o | output | 1 | One-cycle success pulse |
| match_o | output | 4 | Per-pattern match bitfield, valid with success_o |

## Verification
The bench builds the block with its default four patterns and four inputs. This puts every pattern field, every enable bit and the highest field at bits 15:12 within reach of a directed vector table. With only sixteen possible fired vectors, the table can pick exact, superset and subset cases for each field. It also covers the all-patterns-equal case, which makes the whole match vector light at once, and the all-disabled case.

// File: rtl/herald_pkg.sv
package herald_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIT  = 1'b1
    } herald_state_e;
endpackage

// File: rtl/herald_cfg_reg.sv
module herald_cfg_reg #(
    parameter int NUM_PAT = 4,
    parameter int NUM_IN  = 4,
    localparam int CFG_W  = NUM_PAT * NUM_IN + NUM_PAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (we_i) begin
            cfg_o <= wdata_i;
        end
    end
endmodule

// File: rtl/herald_pat_cmp.sv
module herald_pat_cmp #(
    parameter int NUM_IN = 4
) (
    input  logic [NUM_IN-1:0] pattern_i,
    input  logic              enable_i,
    input  logic [NUM_IN-1:0] fired_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = enable_i && (fired_i == pattern_i);
    end
endmodule

// File: rtl/herald_matcher.sv
module herald_matcher #(
    parameter int NUM_PAT = 4,
    parameter int NUM_IN  = 4,
    localparam int CFG_W  = NUM_PAT * NUM_IN + NUM_PAT,
    localparam int EN_LSB = NUM_PAT * NUM_IN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    input  logic [NUM_IN-1:0]  fired_i,
    input  logic               eval_i,
    output logic               success_o,
    output logic [NUM_PAT-1:0] match_o
);
    import herald_pkg::*;

    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_PAT-1:0] hit_vec;
    logic               any_hit;
    logic               take_hit;
    herald_state_e      state_q, state_d;
    logic [NUM_PAT-1:0] match_q, match_d;

    herald_cfg_reg #(.NUM_PAT(NUM_PAT), .NUM_IN(NUM_IN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg_q)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_cmp
        herald_pat_cmp #(.NUM_IN(NUM_IN)) u_cmp (
            .pattern_i (cfg_q[g*NUM_IN +: NUM_IN]),
            .enable_i  (cfg_q[EN_LSB + g]),
            .fired_i   (fired_i),
            .hit_o     (hit_vec[g])
        );
    end

    always_comb begin
        any_hit  = |hit_vec;
        take_hit = eval_i && any_hit;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        match_d = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_hit) begin          // IDLE_TO_HIT
                    state_d = ST_HIT;
                    match_d = hit_vec;
                end
            end
            ST_HIT: begin
                if (take_hit) begin          // HIT_TO_HIT
                    state_d = ST_HIT;
                    match_d = hit_vec;
                end else begin               // HIT_TO_IDLE
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            match_q <= '0;
        end else begin
            state_q <= state_d;
            match_q <= match_d;
        end
    end

    // Outputs
    always_comb begin
        success_o = (state_q == ST_HIT);
        match_o   = success_o ? match_q : '0;
    end
endmodule

// File: rtl/herald_matcher_chk.sv
module herald_matcher_chk #(
    parameter int NUM_PAT = 4,
    parameter int NUM_IN  = 4,
    localparam int CFG_W  = NUM_PAT * NUM_IN + NUM_PAT,
    localparam int EN_LSB = NUM_PAT * NUM_IN
) (
    input logic               clk,
    input logic               rst_n,
    input logic               eval_i,
    input logic [NUM_IN-1:0]  fired_i,
    input logic [CFG_W-1:0]   cfg_q,
    input logic               success_o,
    input logic [NUM_PAT-1:0] match_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!success_o && match_o == '0); // R1
        end
    end

    AST_SUCCESS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> $past(eval_i)); // R7

    AST_SUCCESS_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> (match_o != '0)); // R6

    AST_MATCH_ONLY_WITH_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o != '0) |-> success_o); // R10

    AST_NO_ENABLE_NO_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_q[CFG_W-1:EN_LSB]) == '0) |-> !success_o); // R8

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        AST_EXACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[g] |-> ($past(fired_i) == $past(cfg_q[g*NUM_IN +: NUM_IN]))); // R4
        AST_DISABLED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[g] |-> $past(cfg_q[EN_LSB + g])); // R3
        AST_HIT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(eval_i) && $past(cfg_q[EN_LSB + g])
             && ($past(fired_i) == $past(cfg_q[g*NUM_IN +: NUM_IN])))
            |-> (success_o && match_o[g])); // R5
    end
endmodule

bind herald_matcher herald_matcher_chk #(.NUM_PAT(NUM_PAT), .NUM_IN(NUM_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_i    (eval_i),
    .fired_i   (fired_i),
    .cfg_q     (cfg_q),
    .success_o (success_o),
    .match_o   (match_o)
);

// File: tb/herald_matcher_bench.sv
module herald_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [19:0] cfg_wdata_i = '0;
    logic [3:0]  fired_i = '0;
    logic        eval_i = 1'b0;
    logic        success_o;
    logic [3:0]  match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    herald_matcher u_herald_matcher (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .fired_i     (fired_i),
        .eval_i      (eval_i),
        .success_o   (success_o),
        .match_o     (match_o)
    );

    // {cfg[19:0], fired[3:0], expected match[3:0]}
    localparam int NVEC = 12;
    localparam logic [27:0] VECS [NVEC] = '{
        {20'h1_0001, 4'h1, 4'b0001},  // R2 field 0
        {20'h1_0001, 4'h3, 4'b0000},  // R4 extra input
        {20'h3_00A1, 4'hA, 4'b0010},  // R2 field 1
        {20'h3_00A1, 4'h8, 4'b0000},  // R4 missing input
        {20'hF_5555, 4'h5, 4'b1111},  // R6 all match
        {20'h5_5555, 4'h5, 4'b0101},  // R3 partly disabled
        {20'h0_5555, 4'h5, 4'b0000},  // R8 none enabled
        {20'h8_C000, 4'hC, 4'b1000},  // R2 top field
        {20'h8_C000, 4'h0, 4'b0000},  // R4 nothing fired
        {20'h1_0000, 4'h0, 4'b0001},  // R4 empty pattern
        {20'h4_0F00, 4'hF, 4'b0100},  // R2 field 2
        {20'h2_0030, 4'h3, 4'b0010}   // R3 only pattern 1
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [19:0] v);
        @(negedge clk);
        cfg_we_i    = 1'b1;
        cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i    = 1'b0;
    endtask

    // Strobe once; on return the result cycle is visible.
    task automatic strobe(logic [3:0] f);
        eval_i  = 1'b1;
        fired_i = f;
        @(negedge clk);
        eval_i  = 1'b0;
        fired_i = '0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset success", success_o, 0);
        chk("R1 reset match", match_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        strobe(4'h0);
        chk("R1 cleared config, no success", success_o, 0);

        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VECS[i][27:8]);
            strobe(VECS[i][7:4]);
            chk($sformatf("R5 success vec %0d", i), success_o, (VECS[i][3:0] != 0));
            chk($sformatf("R6 match vec %0d", i), match_o, VECS[i][3:0]);
            @(negedge clk);
            chk($sformatf("R5 pulse ends vec %0d", i), success_o, 0);
            chk($sformatf("R10 match cleared vec %0d", i), match_o, 0);
        end

        // R7: fired inputs without a strobe
        write_cfg(20'h1_0001);
        fired_i = 4'h1;
        repeat (4) begin
            @(negedge clk);
            chk("R7 no strobe", success_o, 0);
        end
        fired_i = '0;

        // R9: write and strobe sampled at the same edge use the old contents
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_wdata_i = 20'h0_0000;
        eval_i = 1'b1;   fired_i = 4'h1;
        @(negedge clk);
        cfg_we_i = 1'b0; eval_i = 1'b0; fired_i = '0;
        chk("R9 old config used", success_o, 1);
        chk("R9 old config match", match_o, 4'b0001);
        @(negedge clk);
        strobe(4'h1);
        chk("R9 new config used", success_o, 0);

        // R5: back-to-back matching strobes
        write_cfg(20'h3_0021);
        eval_i = 1'b1; fired_i = 4'h1;
        @(negedge clk);
        fired_i = 4'h2;
        chk("R5 first of pair", success_o, 1);
        chk("R6 first of pair", match_o, 4'b0001);
        @(negedge clk);
        eval_i = 1'b0; fired_i = '0;
        chk("R5 second of pair", success_o, 1);
        chk("R6 second of pair", match_o, 4'b0010);
        @(negedge clk);
        chk("R5 pair ends", success_o, 0);

        // R1: reset during a success pulse
        write_cfg(20'h1_0001);
        strobe(4'h1);
        chk("R5 before reset", success_o, 1);
        #2 rst_n = 1'b0;
        #1;
        chk("R1 async clear success", success_o, 0);
        chk("R1 async clear match", match_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strobe(4'h1);
        chk("R1 config cleared by reset", success_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule